// File: doc/BRIEF.md
# Counter-Driven Test Observation Multiplexer

This block lets a production tester look at internal register contents through a small number of shared pins. It enters test mode only when an external test pin and a bit in an internal control register are both high. While in test mode, a 4-bit scan index counter steps once on every edge of a dedicated test clock. An up/down input chooses whether each step adds one or subtracts one. The counter's value picks one of sixteen 6-bit register groups for a 6-bit observation output. Its least significant bit picks one of two 8-bit groups for an 8-bit observation port.

The 6-bit observation output shares its pins with a functional 6-bit output. The 8-bit observation port shares its pins with a functional 8-bit input through bidirectional pads. The block drives the pad output value and a per-pin output enable, and it passes the pad's inbound value on to the functional logic. The registers being observed arrive as flat input buses, with group k in bits [k*W +: W]. The pad cells themselves sit outside the block.

There is no data stream here: all pins are plain control and observation signals, with no valid/ready handshake. The observation outputs are combinational from the counter. A new group therefore appears in the same test-clock cycle in which the counter changes.

Top module: `test_obs_mux`

## Requirements
- R1: Test mode is active exactly when `test_pin` and `ctrl_test_bit` are both high. If either input is low, the block behaves as in normal operation.
- R2: When `scan_rst_n` is low at a rising edge of `scan_clk`, the scan counter becomes 0, whatever the mode. After reset, test mode therefore shows group 0.
- R3: In test mode with `count_up` high, each rising edge of `scan_clk` adds one to the counter. The counter wraps from 15 to 0.
- R4: In test mode with `count_up` low, each rising edge of `scan_clk` subtracts one from the counter. The counter wraps from 0 to 15.
- R5: While test mode is inactive, the counter keeps its value. This holds whatever `count_up` does.
- R6: In test mode, `obs6_pin` equals `wide_groups[c*6 +: 6]`, where c is the current counter value. The output follows in the same cycle that the counter changes.
- R7: In test mode, `pad8_out` equals `narrow_groups[b*8 +: 8]`, where b is bit 0 of the counter.
- R8: `pad8_oe` is all ones in test mode and all zeros otherwise. `pad8_out` is all zeros while the enable is low.
- R9: Outside test mode, `obs6_pin` carries `func6_out` and `func8_in` carries `pad8_in`. In test mode, `func8_in` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scan_clk | input | 1 | Dedicated test clock that steps the scan counter |
| scan_rst_n | input | 1 | Synchronous active-low reset of the scan counter |
| test_pin | input | 1 | External test-enable pin |
| ctrl_test_bit | input | 1 | Test-enable bit from the control register |
| count_up | input | 1 | Step direction: 1 adds one, 0 subtracts one |
| wide_groups | input | 96 | Sixteen 6-bit observed groups, group k in bits [k*6 +: 6] |
| narrow_groups | input | 16 | Two 8-bit observed groups, group k in bits [k*8 +: 8] |
| func6_out | input | 6 | Functional value for the shared 6-bit output pins |
| obs6_pin | output | 6 | Shared 6-bit output pins |
| pad8_in | input | 8 | Inbound value from the bidirectional pads |
| pad8_out | output | 8 | Value driven onto the bidirectional pads |
| pad8_oe | output | 8 | Per-pin output enable for the bidirectional pads |
| func8_in | output | 8 | Inbound pad value passed to the functional logic |

## Verification
The counter assertions assume that `scan_rst_n` is low at the first edge of `scan_clk`. The stimulus holds reset low from time zero for several edges and asserts it again in the middle of the run.

All inputs, including `test_pin` and `ctrl_test_bit`, are taken to be stable around each rising edge. The stimulus changes every input only on falling edges, so each edge sees one settled mode and one settled direction.

The hold and pass-through checks rely on test mode being off for the whole cycle being checked. The stimulus therefore includes runs where only one of the two enables is high, with the direction and the pad inputs toggling throughout.

// File: rtl/obs_pkg.sv
`timescale 1ns/100ps
package obs_pkg;
  localparam int unsigned DEF_NUM_WIDE   = 16;
  localparam int unsigned DEF_WIDE_W     = 6;
  localparam int unsigned DEF_NUM_NARROW = 2;
  localparam int unsigned DEF_NARROW_W   = 8;

  typedef enum logic { STEP_DOWN = 1'b0, STEP_UP = 1'b1 } step_dir_e;
endpackage

// File: rtl/scan_counter.sv
`timescale 1ns/100ps
module scan_counter #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  obs_pkg::step_dir_e dir,
  output logic [CW-1:0] idx
);
  localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

  logic [CW-1:0] nxt;

  always_comb begin
    if (dir == obs_pkg::STEP_UP)
      nxt = (idx == LAST) ? '0 : idx + CW'(1);
    else
      nxt = (idx == '0) ? LAST : idx - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= '0;
    else if (step_en) idx <= nxt;
  end
endmodule

// File: rtl/obs_mux.sv
`timescale 1ns/100ps
module obs_mux #(
  parameter int unsigned N = 16,
  parameter int unsigned W = 6,
  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*W-1:0] groups,
  input  logic [SW-1:0]  sel,
  output logic [W-1:0]   y
);
  logic [W-1:0] slot [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign slot[g] = groups[g*W +: W];
  end

  assign y = slot[sel];
endmodule

// File: rtl/pin_share.sv
`timescale 1ns/100ps
module pin_share #(
  parameter int unsigned W = 8,
  parameter bit BIDIR = 1'b1
) (
  input  logic         test_on,
  input  logic [W-1:0] obs_val,
  input  logic [W-1:0] func_val,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] core_in
);
  if (BIDIR) begin : g_bidir
    assign pad_oe  = {W{test_on}};
    assign pad_out = test_on ? obs_val : '0;
    assign core_in = test_on ? '0 : pad_in;
  end else begin : g_out
    assign pad_oe  = '1;
    assign pad_out = test_on ? obs_val : func_val;
    assign core_in = '0;
  end
endmodule

// File: rtl/test_obs_mux.sv
`timescale 1ns/100ps
module test_obs_mux #(
  parameter int unsigned NUM_WIDE   = obs_pkg::DEF_NUM_WIDE,
  parameter int unsigned WIDE_W     = obs_pkg::DEF_WIDE_W,
  parameter int unsigned NUM_NARROW = obs_pkg::DEF_NUM_NARROW,
  parameter int unsigned NARROW_W   = obs_pkg::DEF_NARROW_W
) (
  input  logic                         scan_clk,
  input  logic                         scan_rst_n,
  input  logic                         test_pin,
  input  logic                         ctrl_test_bit,
  input  logic                         count_up,
  input  logic [NUM_WIDE*WIDE_W-1:0]   wide_groups,
  input  logic [NUM_NARROW*NARROW_W-1:0] narrow_groups,
  input  logic [WIDE_W-1:0]            func6_out,
  output logic [WIDE_W-1:0]            obs6_pin,
  input  logic [NARROW_W-1:0]          pad8_in,
  output logic [NARROW_W-1:0]          pad8_out,
  output logic [NARROW_W-1:0]          pad8_oe,
  output logic [NARROW_W-1:0]          func8_in
);
  localparam int unsigned CW = $clog2(NUM_WIDE);
  localparam int unsigned NSW = (NUM_NARROW > 1) ? $clog2(NUM_NARROW) : 1;

  logic                test_on;
  logic [CW-1:0]       scan_idx;
  logic [WIDE_W-1:0]   wide_sel;
  logic [NARROW_W-1:0] narrow_sel;
  logic [WIDE_W-1:0]   unused_oe6;
  logic [WIDE_W-1:0]   unused_core6;

  assign test_on = test_pin & ctrl_test_bit;

  scan_counter #(.DEPTH(NUM_WIDE)) u_cnt (
    .clk    (scan_clk),
    .rst_n  (scan_rst_n),
    .step_en(test_on),
    .dir    (obs_pkg::step_dir_e'(count_up)),
    .idx    (scan_idx)
  );

  obs_mux #(.N(NUM_WIDE), .W(WIDE_W)) u_wide_mux (
    .groups(wide_groups),
    .sel   (scan_idx),
    .y     (wide_sel)
  );

  obs_mux #(.N(NUM_NARROW), .W(NARROW_W)) u_narrow_mux (
    .groups(narrow_groups),
    .sel   (scan_idx[NSW-1:0]),
    .y     (narrow_sel)
  );

  pin_share #(.W(WIDE_W), .BIDIR(1'b0)) u_share6 (
    .test_on (test_on),
    .obs_val (wide_sel),
    .func_val(func6_out),
    .pad_in  ('0),
    .pad_out (obs6_pin),
    .pad_oe  (unused_oe6),
    .core_in (unused_core6)
  );

  pin_share #(.W(NARROW_W), .BIDIR(1'b1)) u_share8 (
    .test_on (test_on),
    .obs_val (narrow_sel),
    .func_val('0),
    .pad_in  (pad8_in),
    .pad_out (pad8_out),
    .pad_oe  (pad8_oe),
    .core_in (func8_in)
  );
endmodule

// File: rtl/test_obs_mux_chk.sv
`timescale 1ns/100ps
module test_obs_mux_chk #(
  parameter int unsigned CW = 4,
  parameter int unsigned NW = 8
) (
  input logic          scan_clk,
  input logic          scan_rst_n,
  input logic          test_pin,
  input logic          ctrl_test_bit,
  input logic          count_up,
  input logic [CW-1:0] scan_idx,
  input logic [NW-1:0] pad8_in,
  input logic [NW-1:0] pad8_out,
  input logic [NW-1:0] pad8_oe,
  input logic [NW-1:0] func8_in
);
  logic mode;
  assign mode = test_pin && ctrl_test_bit;

  AST_RESET_ZERO: assert property (@(posedge scan_clk)
    !scan_rst_n |=> scan_idx == '0); // R2

  AST_STEP_UP: assert property (@(posedge scan_clk) disable iff (!scan_rst_n)
    (mode && count_up) |=> scan_idx == CW'($past(scan_idx) + 1'b1)); // R3

  AST_STEP_DOWN: assert property (@(posedge scan_clk) disable iff (!scan_rst_n)
    (mode && !count_up) |=> scan_idx == CW'($past(scan_idx) - 1'b1)); // R4

  AST_IDLE_HOLD: assert property (@(posedge scan_clk) disable iff (!scan_rst_n)
    !mode |=> $stable(scan_idx)); // R5

  AST_OE_TEST: assert property (@(posedge scan_clk) disable iff (!scan_rst_n)
    mode |-> (&pad8_oe)); // R8

  AST_OE_IDLE: assert property (@(posedge scan_clk) disable iff (!scan_rst_n)
    !mode |-> (pad8_oe == '0 && pad8_out == '0)); // R8

  AST_PAD_PASS: assert property (@(posedge scan_clk) disable iff (!scan_rst_n)
    !mode |-> func8_in == pad8_in); // R9
endmodule

bind test_obs_mux test_obs_mux_chk #(.CW(CW), .NW(NARROW_W)) u_chk (
  .scan_clk     (scan_clk),
  .scan_rst_n   (scan_rst_n),
  .test_pin     (test_pin),
  .ctrl_test_bit(ctrl_test_bit),
  .count_up     (count_up),
  .scan_idx     (scan_idx),
  .pad8_in      (pad8_in),
  .pad8_out     (pad8_out),
  .pad8_oe      (pad8_oe),
  .func8_in     (func8_in)
);

// File: tb/test_obs_mux_tb_top.sv
`timescale 1ns/100ps
module test_obs_mux_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tp = 1'b1;
  logic        cb = 1'b1;
  logic        up = 1'b1;
  logic [95:0] wide = '0;
  logic [15:0] narrow = '0;
  logic [5:0]  f6 = '0;
  logic [7:0]  pin8 = '0;
  logic [5:0]  obs6;
  logic [7:0]  p8o, p8oe, f8;

  int checks = 0;
  int failures = 0;
  int m_cnt = 0;
  string tag = "R2";

  always #2.5 clk = ~clk;

  test_obs_mux dut_i (
    .scan_clk(clk), .scan_rst_n(rst_n), .test_pin(tp), .ctrl_test_bit(cb),
    .count_up(up), .wide_groups(wide), .narrow_groups(narrow),
    .func6_out(f6), .obs6_pin(obs6), .pad8_in(pin8), .pad8_out(p8o),
    .pad8_oe(p8oe), .func8_in(f8)
  );

  // Behavioural model of the scan index (R2..R5)
  always @(posedge clk) begin
    if (!rst_n) m_cnt = 0;
    else if (tp && cb) m_cnt = up ? (m_cnt + 1) % 16 : (m_cnt + 15) % 16;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit mode;
    logic [5:0] e6;
    logic [7:0] e8o, e8oe, e8f;
    mode = tp && cb;
    e6   = mode ? wide[m_cnt*6 +: 6] : f6;
    e8o  = mode ? narrow[(m_cnt % 2)*8 +: 8] : 8'h00;
    e8oe = mode ? 8'hFF : 8'h00;
    e8f  = mode ? 8'h00 : pin8;
    chk(mode ? {tag, "/R6"} : {tag, "/R9"}, {2'b0, obs6}, {2'b0, e6});
    chk(mode ? "R7" : "R8", p8o, e8o);
    chk({tag, "/R8"}, p8oe, e8oe);
    chk({tag, "/R9"}, f8, e8f);
  endtask

  task automatic cycles(input int n, input int mode_sel, input int dir_sel);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      wide   = {$urandom, $urandom, $urandom};
      narrow = 16'($urandom);
      f6     = 6'($urandom);
      pin8   = 8'($urandom);
      case (mode_sel)
        0: begin tp = 1'b1; cb = 1'b1; end
        1: begin tp = 1'b1; cb = 1'b0; end
        2: begin tp = 1'b0; cb = 1'b1; end
        3: begin tp = 1'b0; cb = 1'b0; end
        default: begin tp = 1'($urandom); cb = 1'($urandom); end
      endcase
      case (dir_sel)
        0: up = 1'b0;
        1: up = 1'b1;
        default: up = 1'($urandom);
      endcase
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tag = "R2";
    cycles(4, 0, 1);              // reset with mode on: index stays 0
    rst_n = 1'b1;
    tag = "R3";
    cycles(20, 0, 1);             // count up across 15 -> 0
    tag = "R4";
    cycles(24, 0, 0);             // count down across 0 -> 15
    tag = "R1";
    cycles(10, 1, 2);             // only test pin: normal operation
    cycles(10, 2, 2);             // only control bit: normal operation
    tag = "R5";
    cycles(10, 3, 2);             // idle: index held
    tag = "R4";
    cycles(3, 0, 0);
    tag = "R2";
    rst_n = 1'b0;
    cycles(3, 0, 0);              // mid-run reset
    rst_n = 1'b1;
    tag = "R3";
    cycles(5, 0, 1);
    tag = "R1";
    cycles(300, 4, 2);            // random modes and directions
    @(negedge clk);
    compare();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule